// File: doc/BRIEF.md
# Dual Tick Timer: One-Shot Countdown and Periodic Interval

This block holds two independent 32-bit tick timers behind a small register window. One timer fires once and then disarms itself. The other fires again and again at a programmed interval. Each timer has a control word that holds the programmed tick count and a read-only word that gives the live number of ticks left. Each timer also drives its own expiry pulse, one clock wide, which is meant to serve as an interrupt source.

Time advances only on clock cycles where `tick_en` is high. A write to a control word reloads that timer at once: any expiry still pending is dropped, and counting starts again from the write. Bus data is big-endian. The register window is accessed in the same cycle as the request, with read data and the error flag driven combinationally. A request of the wrong size is flagged as an error and has no effect.

Top module: `tick_timer_pair`

## Requirements
- R1: The window decodes offset 40 as interval control (read/write), 36 as one-shot remaining (read), 44 as interval remaining (read) and 32 as one-shot control (read/write). Bits [8k+7:8k] of `req_wdata` and `rsp_rdata` carry the byte at address offset+k, so the byte in bits [7:0] is the most significant byte of the value. Any other offset reads as zero, has `rsp_err` low, and ignores writes.
- R2: A request to one of the four offsets with `req_size` other than 4 sets `rsp_err` in that cycle, returns zero read data, and changes no state.
- R3: A write of N to a control word sets both control and remaining to N from the next cycle. N = 0 stops the timer. A nonzero N makes the timer expire on the Nth following tick.
- R4: A control write drops any pending expiry and restarts counting. When a write and a tick fall in the same cycle, the write wins, and no expiry pulse follows that cycle.
- R5: A read of a control word returns the last value written to it. The one exception is the one-shot after it expires (R6).
- R6: When the one-shot expires, `cd_expire` is high in the cycle after the expiring tick edge. From then on its control and remaining words read zero and it does not fire again.
- R7: When the interval timer expires, `pt_expire` pulses and its remaining word reloads to the programmed period, so it fires on every Pth tick.
- R8: The remaining word decrements by one only on cycles with `tick_en` high while its timer is armed. It reads zero whenever the control word is zero.
- R9: Writes to either remaining offset are ignored.
- R10: Each expiry raises its pulse for exactly one clock cycle.
- R11: After reset both control words and both remaining words are zero, and neither expiry output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 6 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, big-endian byte lanes |
| tick_en | input | 1 | Advances time by one tick when high |
| rsp_rdata | output | 32 | Read data, big-endian byte lanes, same cycle |
| rsp_err | output | 1 | Size error for this request |
| cd_expire | output | 1 | One-shot expiry pulse |
| pt_expire | output | 1 | Interval expiry pulse |

## Verification
A corrupted remaining count shows up in one of two places. It appears on the next read of the remaining offset. It also appears as an expiry pulse that comes one or more ticks early or late, and for the interval timer that error repeats every period. A one-shot that fails to clear shows up either as a second pulse or as a nonzero control readback right after the first pulse. The bench compares both pulses every cycle and checks every read response in the cycle it is issued. A wrong state is therefore reported no later than the next tick that should have changed it, or the next read.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int WORD_W  = 32;
  localparam int NBYTES  = WORD_W / 8;
  localparam int NTIMERS = 2;

  typedef logic [WORD_W-1:0] word_t;

  localparam int OFS_ONESHOT_CTRL = 32;
  localparam int OFS_ONESHOT_LEFT = 36;
  localparam int OFS_PERIOD_CTRL  = 40;
  localparam int OFS_PERIOD_LEFT  = 44;

  // Reverse byte order between the bus lanes and the numeric value.
  function automatic word_t lane_swap(input word_t w);
    word_t r;
    for (int b = 0; b < NBYTES; b++) begin
      r[8*b +: 8] = w[8*(NBYTES-1-b) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter bit PERIODIC = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_en,
  input  logic  ld_en,
  input  word_t ld_val,
  output word_t period_o,
  output word_t remain_o,
  output logic  expire_o
);
  word_t period_q, period_d;
  word_t remain_q, remain_d;
  logic  pulse_q, pulse_d;
  logic  armed;

  assign armed = (period_q != '0);

  always_comb begin
    period_d = period_q;
    remain_d = remain_q;
    pulse_d  = 1'b0;
    if (ld_en) begin
      period_d = ld_val;
      remain_d = ld_val;
    end else if (tick_en && armed) begin
      if (remain_q == word_t'(1)) begin
        pulse_d = 1'b1;
        if (PERIODIC) begin
          remain_d = period_q;
        end else begin
          period_d = '0;
          remain_d = '0;
        end
      end else begin
        remain_d = remain_q - word_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      remain_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      period_q <= period_d;
      remain_q <= remain_d;
      pulse_q  <= pulse_d;
    end
  end

  assign period_o = period_q;
  assign remain_o = remain_q;
  assign expire_o = pulse_q;

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (period_q == $past(ld_val)) && (remain_q == $past(ld_val)) && !pulse_q); // R4
  AST_EXPIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(tick_en) && !$past(ld_en) && ($past(remain_q) == word_t'(1))); // R10
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_en) |=> $stable(remain_q) && $stable(period_q)); // R8
  AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) |-> (remain_q == '0)); // R8

  generate
    if (PERIODIC) begin : g_reload_chk
      AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (remain_q == period_q) && (period_q != '0)); // R7
    end else begin : g_clear_chk
      AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (period_q == '0) && (remain_q == '0)); // R6
    end
  endgenerate
endmodule

// File: rtl/tt_regif.sv
module tt_regif
  import tt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [2:0]        req_size,
  input  word_t             req_wdata,
  input  word_t             period_i [NTIMERS],
  input  word_t             remain_i [NTIMERS],
  output logic [NTIMERS-1:0] ld_en,
  output word_t             ld_val,
  output word_t             rsp_rdata,
  output logic              rsp_err
);
  logic hit;
  logic size_ok;
  logic sel_timer;
  logic sel_left;
  word_t value;

  assign hit = (int'(req_offset) == OFS_ONESHOT_CTRL) || (int'(req_offset) == OFS_ONESHOT_LEFT) ||
               (int'(req_offset) == OFS_PERIOD_CTRL)  || (int'(req_offset) == OFS_PERIOD_LEFT);
  assign size_ok   = (int'(req_size) == NBYTES);
  assign sel_timer = req_offset[3];
  assign sel_left  = req_offset[2];
  assign ld_val    = lane_swap(req_wdata);
  assign rsp_err   = req_valid && hit && !size_ok;

  generate
    for (genvar g = 0; g < NTIMERS; g++) begin : g_load
      assign ld_en[g] = req_valid && req_write && hit && size_ok && !sel_left &&
                        (sel_timer == g[0]);
    end
  endgenerate

  always_comb begin
    value = sel_left ? remain_i[sel_timer] : period_i[sel_timer];
    rsp_rdata = '0;
    if (req_valid && !req_write && hit && size_ok) begin
      rsp_rdata = lane_swap(value);
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              tick_en,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              cd_expire,
  output logic              pt_expire
);
  logic rst_sync_n;
  logic [NTIMERS-1:0] ld_en;
  word_t ld_val;
  word_t period_w [NTIMERS];
  word_t remain_w [NTIMERS];
  logic [NTIMERS-1:0] expire_w;

  tt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tt_regif #(.ADDR_W(ADDR_W)) u_regif (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_offset (req_offset),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .period_i   (period_w),
    .remain_i   (remain_w),
    .ld_en      (ld_en),
    .ld_val     (ld_val),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err)
  );

  generate
    for (genvar g = 0; g < NTIMERS; g++) begin : g_tmr
      tt_counter #(.PERIODIC(g == 1)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .tick_en  (tick_en),
        .ld_en    (ld_en[g]),
        .ld_val   (ld_val),
        .period_o (period_w[g]),
        .remain_o (remain_w[g]),
        .expire_o (expire_w[g])
      );
    end
  endgenerate

  assign cd_expire = expire_w[0];
  assign pt_expire = expire_w[1];

  AST_ERR_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (ld_en == '0)); // R2
  AST_ONE_LOAD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ld_en)); // R1
  AST_NO_PULSE_IN_RESET: assert property (@(posedge clk)
    !rst_sync_n |-> !cd_expire && !pt_expire); // R11
endmodule

// File: tb/tick_timer_pair_tb.sv
module tick_timer_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, tick_en;
  logic [5:0]  req_offset;
  logic [2:0]  req_size;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_err, cd_expire, pt_expire;

  int checks = 0;
  int errors = 0;

  // reference model state
  int unsigned m_per [2];
  int unsigned m_rem [2];
  bit          m_pulse [2];

  always #4 clk = ~clk;

  tick_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .tick_en(tick_en), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cd_expire(cd_expire), .pt_expire(pt_expire)
  );

  function automatic logic [31:0] to_bus(input int unsigned v);
    logic [31:0] r;
    r[7:0]   = v[31:24];
    r[15:8]  = v[23:16];
    r[23:16] = v[15:8];
    r[31:24] = v[7:0];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit v, input bit w, input int off,
                     input int sz, input int unsigned val, input bit tk);
    bit hit;
    int t;
    @(negedge clk);
    req_valid = v; req_write = w; req_offset = off[5:0]; req_size = sz[2:0];
    req_wdata = to_bus(val); tick_en = tk;
    #1;
    check({tag, "/R10 one-shot pulse"}, 32'(cd_expire), 32'(m_pulse[0]));
    check({tag, "/R10 interval pulse"}, 32'(pt_expire), 32'(m_pulse[1]));
    hit = (off == 32) || (off == 36) || (off == 40) || (off == 44);
    t = (off >= 40) ? 1 : 0;
    if (v) begin
      check({tag, " err"}, 32'(rsp_err), 32'(hit && sz != 4));
      if (!w) begin
        if (!hit || sz != 4) check({tag, " rdata"}, rsp_rdata, 32'h0);
        else if (off == 32 || off == 40) check({tag, " ctrl rdata"}, rsp_rdata, to_bus(m_per[t]));
        else check({tag, " left rdata"}, rsp_rdata, to_bus(m_per[t] != 0 ? m_rem[t] : 0));
      end
    end
    for (int i = 0; i < 2; i++) begin
      m_pulse[i] = 1'b0;
      if (v && w && sz == 4 && off == (i == 0 ? 32 : 40)) begin
        m_per[i] = val; m_rem[i] = val;
      end else if (tk && m_per[i] != 0) begin
        if (m_rem[i] == 1) begin
          m_pulse[i] = 1'b1;
          if (i == 1) m_rem[i] = m_per[i];
          else begin m_per[i] = 0; m_rem[i] = 0; end
        end else m_rem[i] = m_rem[i] - 1;
      end
    end
  endtask

  task automatic idle(input string tag, input int n, input bit tk);
    for (int k = 0; k < n; k++) cyc(tag, 0, 0, 0, 4, 0, tk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_offset = 0; req_size = 4;
    req_wdata = 0; tick_en = 0;
    for (int i = 0; i < 2; i++) begin m_per[i] = 0; m_rem[i] = 0; m_pulse[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R11", 3, 1'b0);
    // R11 reset values through the bus
    cyc("R11", 1, 0, 32, 4, 0, 0);
    cyc("R11", 1, 0, 36, 4, 0, 1);
    cyc("R11", 1, 0, 40, 4, 0, 1);
    cyc("R11", 1, 0, 44, 4, 0, 0);
    // R1 byte order on readback
    cyc("R1", 1, 1, 40, 4, 32'h0102_0304, 0);
    cyc("R1", 1, 0, 40, 4, 0, 0);
    cyc("R1", 1, 0, 8, 4, 0, 0);
    cyc("R1", 1, 1, 8, 4, 5, 1);
    cyc("R3", 1, 1, 40, 4, 0, 0);
    // R3/R6 one-shot of 3 ticks with gaps
    cyc("R3", 1, 1, 32, 4, 3, 0);
    cyc("R8", 1, 0, 36, 4, 0, 1);
    cyc("R8", 1, 0, 36, 4, 0, 0);
    cyc("R8", 1, 0, 36, 4, 0, 1);
    cyc("R6", 1, 0, 36, 4, 0, 1);
    cyc("R6", 1, 0, 32, 4, 0, 1);
    cyc("R6", 1, 0, 36, 4, 0, 1);
    idle("R6", 5, 1'b1);
    // R7 periodic of 2
    cyc("R7", 1, 1, 40, 4, 2, 0);
    idle("R7", 8, 1'b1);
    cyc("R5", 1, 0, 40, 4, 0, 1);
    cyc("R7", 1, 0, 44, 4, 0, 1);
    // R7 period of 1 fires on every tick
    cyc("R7", 1, 1, 40, 4, 1, 0);
    idle("R7", 4, 1'b1);
    // R4 rewrite mid-count and write in expiring cycle
    cyc("R4", 1, 1, 32, 4, 4, 0);
    idle("R4", 3, 1'b1);
    cyc("R4", 1, 1, 32, 4, 2, 1);
    cyc("R4", 1, 0, 36, 4, 0, 1);
    idle("R4", 3, 1'b1);
    // R2 bad sizes
    cyc("R2", 1, 1, 32, 2, 9, 1);
    cyc("R2", 1, 0, 40, 1, 0, 0);
    cyc("R2", 1, 1, 40, 3, 7, 1);
    cyc("R2", 1, 0, 32, 4, 0, 0);
    // R9 remaining writes ignored
    cyc("R9", 1, 1, 44, 4, 99, 0);
    cyc("R9", 1, 0, 44, 4, 0, 0);
    cyc("R9", 1, 1, 36, 4, 7, 0);
    cyc("R9", 1, 0, 36, 4, 0, 0);
    // R3 stop with zero
    cyc("R3", 1, 1, 40, 4, 0, 1);
    cyc("R3", 1, 0, 44, 4, 0, 1);
    idle("R3", 4, 1'b1);
    // R8 randomised traffic
    for (int k = 0; k < 3000; k++) begin
      int sel, off, sz;
      sel = $urandom_range(0, 5);
      off = (sel == 5) ? 12 : 32 + 4 * (sel % 4);
      sz  = ($urandom_range(0, 9) == 0) ? 2 : 4;
      cyc("R8", $urandom_range(0, 2) != 0, $urandom_range(0, 5) == 0, off, sz,
          $urandom_range(0, 6), $urandom_range(0, 3) != 0);
    end
    idle("R10", 2, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule